// File: doc/BRIEF.md
# Electroluminescent Backlight Clock Driver

This block produces the two gated clocks that drive an electroluminescent backlight converter. One is a pump clock (`elp`) for the inductor switch and the other is a polarity clock (`elc`) for the panel bridge. All source clocks arrive as level signals that are synchronous to the block clock `clk`. The pump clock starts from either an alternate base clock or prescaler stage 0. That choice then goes through a power-of-two divider. The polarity clock starts from one of four prescaler taps. Each output has its own duty selection. With duty 1/N, the output follows the high half of its source in one source period out of every N.

A one-cycle `light_on` strobe starts the polarity clock first. The pump clock is released only after the polarity clock has been seen high. A one-cycle `light_off` strobe lets both clocks run on until the next falling edge of the polarity clock. At that edge both outputs are forced low, so no charge is left stranded on the panel. A configuration word is held in a pending register. Each channel adopts it at its own period boundary while running, and at once while the light is dark. A flag in the word requests a one-cycle `halt_req` pulse when the shutdown completes.

Top module: `el_pump_drv`

## Requirements
- R1: While `lit` is low (after reset and after a completed shutdown), `elp` and `elc` stay low whatever the source clocks do.
- R2: `cfg_in[5:4]` selects the `elc` source: 11 picks `ph_tap[0]` (tap 5), 10 picks `ph_tap[1]` (tap 6), 01 picks `ph_tap[2]` (tap 7) and 00 picks `ph_tap[3]` (tap 8).
- R3: `cfg_in[8]` selects the `elp` base: 1 is `alt_clk` and 0 is `ph0`. `cfg_in[7:6]` divides that base: 11 by 8, 10 by 4, 01 by 2 and 00 by 1.
- R4: The duty fields are `cfg_in[1:0]` for `elp` and `cfg_in[3:2]` for `elc`. The codes are 11 for 1/1, 10 for 1/2, 01 for 1/3 and 00 for 1/4. With duty 1/N, the output period is N source periods, and the output is high for the high half of one of them.
- R5: After `light_on`, `elp` is low in the first lit cycle, and the first rise of `elp` comes strictly after the first rise of `elc`.
- R6: After `light_off`, both outputs keep running until the next falling edge of `elc`. In that same cycle `lit` and `elp` go low.
- R7: `lit` is high from the cycle after a `light_on` strobe until the shutdown has completed.
- R8: `halt_req` is a single-cycle pulse, in the cycle `lit` falls, if `cfg_in[9]` was set. Otherwise it never pulses.
- R9: A configuration written while running takes effect at each channel's next period boundary. A configuration written while dark takes effect at once.
- R10: A `light_on` during a pending shutdown cancels it and the outputs keep running. When both strobes arrive together, `light_off` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Loads `cfg_in` into the pending configuration |
| cfg_in | input | 10 | Configuration word (fields in R2, R3, R4, R8) |
| light_on | input | 1 | One-cycle turn-on strobe |
| light_off | input | 1 | One-cycle turn-off strobe |
| alt_clk | input | 1 | Alternate pump base clock level |
| ph0 | input | 1 | Prescaler stage 0 clock level |
| ph_tap | input | 4 | Prescaler taps 5..8, bit 0 is tap 5 |
| elp | output | 1 | Pump clock |
| elc | output | 1 | Polarity clock |
| lit | output | 1 | High while the light is on or stopping |
| halt_req | output | 1 | One-cycle halt request at shutdown completion |

## Verification
The assertions assume that the source clock levels are synchronous to `clk` and are stable for at least one cycle between changes. They also assume that the strobes are single-cycle pulses. The phase-bound checks further assume that a duty change lands only at a period boundary, which the design itself ensures. The bench derives every source from one free-running counter that is advanced on the falling edge of `clk`. It drives each strobe for exactly one cycle. It keeps `elc` sources running during any shutdown, so the awaited falling edge always arrives.

// File: rtl/el_pump_drv.sv
module el_pump_drv (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [9:0] cfg_in,
  input  logic       light_on,
  input  logic       light_off,
  input  logic       alt_clk,
  input  logic       ph0,
  input  logic [3:0] ph_tap,
  output logic       elp,
  output logic       elc,
  output logic       lit,
  output logic       halt_req
);

  typedef enum logic [1:0] {S_OFF, S_START, S_RUN, S_STOP} st_t;

  st_t        st;
  logic [9:0] pend;
  logic       p_go;

  always_ff @(posedge clk)
    if (!rst_n)      pend <= '0;
    else if (cfg_wr) pend <= cfg_in;

  // polarity clock channel
  logic [1:0] c_tap, c_duty, c_ph, c_last, c_idx;
  logic       c_src, c_src_q, c_fall, c_en, c_raw;

  assign c_idx  = ~c_tap;
  assign c_src  = ph_tap[c_idx];
  assign c_last = ~c_duty;
  assign c_fall = c_src_q & ~c_src;
  assign c_en   = (st != S_OFF);
  assign c_raw  = c_en & c_src & (c_ph == 2'd0);

  always_ff @(posedge clk)
    if (!rst_n) begin
      c_src_q <= 1'b0;
      c_ph    <= '0;
      c_tap   <= '0;
      c_duty  <= '0;
    end else begin
      c_src_q <= c_src;
      if (!c_en) begin
        c_ph   <= '0;
        c_tap  <= pend[5:4];
        c_duty <= pend[3:2];
      end else if (c_fall) begin
        if (c_ph == c_last) begin
          c_ph   <= '0;
          c_tap  <= pend[5:4];
          c_duty <= pend[3:2];
        end else begin
          c_ph <= c_ph + 2'd1;
        end
      end
    end

  // pump clock channel
  logic       p_alt, p_base, p_base_q, p_src, p_src_q, p_fall;
  logic [1:0] p_div, p_duty, p_ph, p_last;
  logic [2:0] dcnt;

  assign p_base = p_alt ? alt_clk : ph0;
  assign p_last = ~p_duty;
  assign p_fall = p_src_q & ~p_src;

  always_comb
    case (p_div)
      2'b00:   p_src = p_base;
      2'b01:   p_src = dcnt[0];
      2'b10:   p_src = dcnt[1];
      default: p_src = dcnt[2];
    endcase

  always_ff @(posedge clk)
    if (!rst_n) begin
      p_base_q <= 1'b0;
      p_src_q  <= 1'b0;
      dcnt     <= '0;
      p_ph     <= '0;
      p_alt    <= 1'b0;
      p_div    <= '0;
      p_duty   <= '0;
    end else begin
      p_base_q <= p_base;
      p_src_q  <= p_src;
      if (p_base && !p_base_q) dcnt <= dcnt + 3'd1;
      if (!p_go) begin
        p_ph   <= '0;
        p_alt  <= pend[8];
        p_div  <= pend[7:6];
        p_duty <= pend[1:0];
      end else if (p_fall) begin
        if (p_ph == p_last) begin
          p_ph   <= '0;
          p_alt  <= pend[8];
          p_div  <= pend[7:6];
          p_duty <= pend[1:0];
        end else begin
          p_ph <= p_ph + 2'd1;
        end
      end
    end

  // sequencing
  logic stop_done;
  assign stop_done = (st == S_STOP) & elc & ~c_raw;
  assign lit = (st != S_OFF);

  always_ff @(posedge clk)
    if (!rst_n) begin
      st       <= S_OFF;
      p_go     <= 1'b0;
      elc      <= 1'b0;
      elp      <= 1'b0;
      halt_req <= 1'b0;
    end else begin
      elc      <= c_raw;
      elp      <= p_go & p_src & (p_ph == 2'd0) & ~stop_done;
      halt_req <= stop_done & pend[9];
      if (stop_done)                    p_go <= 1'b0;
      else if (st == S_START && elc)    p_go <= 1'b1;
      case (st)
        S_OFF:   if (light_on && !light_off) st <= S_START;
        S_START: if (light_off) st <= S_STOP;
                 else if (elc)  st <= S_RUN;
        S_RUN:   if (light_off) st <= S_STOP;
        S_STOP:  if (stop_done) st <= S_OFF;
                 else if (light_on && !light_off) st <= p_go ? S_RUN : S_START;
        default: st <= S_OFF;
      endcase
    end

  // R1
  dark_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lit |-> (!elp && !elc));

  // R4
  phase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_ph <= c_last) && (p_ph <= p_last));

  // R5
  pump_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lit) |-> !elp);

  // R6
  stop_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lit) |-> ($fell(elc) && !elp));

  // R8
  halt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> $fell(lit));

endmodule

// File: tb/el_pump_drv_tb.sv
module el_pump_drv_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 1'b0, light_on = 1'b0, light_off = 1'b0;
  logic [9:0] cfg_in = '0;
  logic [5:0] src_cnt = '0;
  logic elp, elc, lit, halt_req;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) src_cnt <= src_cnt + 6'd1;

  el_pump_drv u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_in(cfg_in),
    .light_on(light_on), .light_off(light_off),
    .alt_clk(src_cnt[2]), .ph0(src_cnt[0]), .ph_tap(src_cnt[4:1]),
    .elp(elp), .elc(elc), .lit(lit), .halt_req(halt_req));

  typedef struct packed {
    logic [9:0]  cfg;
    logic [15:0] c_per, c_hi, p_per, p_hi;
  } vec_t;

  // ph0 period 2, alt period 8, taps 5..8 periods 4/8/16/32
  localparam vec_t VECS [6] = '{
    '{10'b0_0_00_11_11_11, 16'd4,   16'd2,  16'd2,  16'd1},
    '{10'b0_0_01_10_10_10, 16'd16,  16'd4,  16'd8,  16'd2},
    '{10'b0_1_00_01_01_01, 16'd48,  16'd8,  16'd24, 16'd4},
    '{10'b0_0_11_00_00_00, 16'd128, 16'd16, 16'd64, 16'd8},
    '{10'b0_1_10_11_00_11, 16'd16,  16'd2,  16'd32, 16'd16},
    '{10'b0_0_10_10_11_01, 16'd8,   16'd4,  16'd24, 16'd4}
  };

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WD_LIMIT);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [9:0] v);
    @(negedge clk); cfg_in = v; cfg_wr = 1'b1;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  function automatic logic sig(input bit pick_elp);
    return pick_elp ? elp : elc;
  endfunction

  task automatic measure(input bit pick_elp, output int per, output int hi);
    do @(negedge clk); while (sig(pick_elp));
    do @(negedge clk); while (!sig(pick_elp));
    hi = 0;
    while (sig(pick_elp)) begin hi++; @(negedge clk); end
    per = hi;
    while (!sig(pick_elp)) begin per++; @(negedge clk); end
  endtask

  task automatic go_on(output int tc, output int tp);
    int t;
    @(negedge clk); light_on = 1'b1;
    @(negedge clk); light_on = 1'b0;
    chk(lit === 1'b1, "R7 lit after on", int'(lit), 1);
    chk(elp === 1'b0, "R5 elp low first lit cycle", int'(elp), 0);
    tc = -1; tp = -1; t = 0;
    while (tp < 0) begin
      if (elc && tc < 0) tc = t;
      if (elp && tp < 0) tp = t;
      t++;
      @(negedge clk);
    end
  endtask

  task automatic go_off(output bit edge_ok, output int halts);
    logic pe;
    @(negedge clk); light_off = 1'b1; pe = elc; halts = 0;
    @(negedge clk); light_off = 1'b0;
    while (lit) begin
      pe = elc;
      @(negedge clk);
    end
    edge_ok = pe && !elc && !elp;
    if (halt_req) halts++;
    repeat (10) begin
      @(negedge clk);
      if (halt_req) halts++;
    end
  endtask

  initial begin
    int tc, tp, per, hi, halts, seen;
    bit eok;

    tick(3);
    chk({elp, elc, lit, halt_req} == 4'b0, "R1 reset outputs", int'({elp, elc, lit, halt_req}), 0);
    rst_n = 1'b1;
    seen = 0;
    repeat (40) begin @(negedge clk); if (elp || elc || lit) seen++; end
    chk(seen == 0, "R1 dark after reset", seen, 0);

    for (int i = 0; i < 6; i++) begin
      wr_cfg(VECS[i].cfg);
      go_on(tc, tp);
      chk(tc < tp, "R5 elc rises before elp", tc, tp);
      tick(400);
      measure(1'b0, per, hi);
      chk(per == int'(VECS[i].c_per), "R2 R4 elc period", per, int'(VECS[i].c_per));
      chk(hi == int'(VECS[i].c_hi), "R4 elc high time", hi, int'(VECS[i].c_hi));
      measure(1'b1, per, hi);
      chk(per == int'(VECS[i].p_per), "R3 R4 elp period", per, int'(VECS[i].p_per));
      chk(hi == int'(VECS[i].p_hi), "R3 R4 elp high time", hi, int'(VECS[i].p_hi));
      go_off(eok, halts);
      chk(eok, "R6 stop on elc falling edge", int'(eok), 1);
      chk(halts == 0, "R8 no halt request", halts, 0);
    end

    seen = 0;
    repeat (100) begin @(negedge clk); if (elp || elc) seen++; end
    chk(seen == 0, "R1 outputs held low while dark", seen, 0);

    wr_cfg(10'b1_0_00_11_11_11);
    go_on(tc, tp);
    tick(50);
    go_off(eok, halts);
    chk(halts == 1, "R8 one halt pulse", halts, 1);
    chk(eok, "R6 stop edge with halt", int'(eok), 1);

    wr_cfg(VECS[0].cfg);
    go_on(tc, tp);
    tick(100);
    wr_cfg(VECS[1].cfg);
    tick(400);
    measure(1'b0, per, hi);
    chk(per == 16, "R9 elc adopts new config", per, 16);
    measure(1'b1, per, hi);
    chk(per == 8, "R9 elp adopts new config", per, 8);
    go_off(eok, halts);

    wr_cfg(VECS[3].cfg);
    go_on(tc, tp);
    tick(300);
    do @(negedge clk); while (!elc);
    do @(negedge clk); while (elc);
    light_off = 1'b1;
    @(negedge clk); light_off = 1'b0;
    tick(2);
    light_on = 1'b1;
    @(negedge clk); light_on = 1'b0;
    tick(400);
    chk(lit === 1'b1, "R10 on cancels shutdown", int'(lit), 1);
    measure(1'b0, per, hi);
    chk(per == 128, "R10 elc keeps running", per, 128);

    @(negedge clk); light_on = 1'b1; light_off = 1'b1;
    @(negedge clk); light_on = 1'b0; light_off = 1'b0;
    tick(300);
    chk(lit === 1'b0, "R10 off wins on simultaneous strobes", int'(lit), 0);
    chk(!elp && !elc, "R1 outputs low after shutdown", int'({elp, elc}), 0);

    summary();
    $finish;
  end
endmodule